// File: doc/BRIEF.md
# PWM Periodic Comparison Bank

A bank of identical comparison units that all watch one shared PWM period counter. Each unit holds a compare value and a small configuration word. It emits a single-cycle pulse when the counter reaches its value. Matching is qualified in three ways. A per-unit period-skip counter lets only one counter period out of every N take part. A direction qualifier applies while the counter runs center-aligned. A fault input turns matching off for every unit. Downstream logic can use each pulse as an event line, an interrupt source or a DMA request. A sticky status bit per unit records that a pulse has happened.

Software writes each setting either to its live register, which takes effect on the next clock, or to its shadow register. A shadow register is copied into the live register at the next end-of-period strobe, and only if it was written since the last copy. This lets settings change while the counter runs without a period ever seeing a mix of old and new fields. The write port is a plain strobe with no ready signal. Every write is accepted in the cycle it is presented, so there is no back-pressure. The counter, fault detection and the pulse consumers are outside this block.

Top module: `pcmp_bank`

## Requirements
- R1: After reset, all match pulses and status bits are 0 and every unit is disabled, so a counter equal to the reset compare value of 0 raises no pulse.
- R2: An enabled unit whose qualifiers all hold raises its match bit in the clock after the cycle in which the counter equals its compare value.
- R3: When center mode is on, a unit matches only while the counter direction equals the unit's direction bit (1 = counting down). When center mode is off, the direction bit and counter direction have no effect.
- R4: While the fault input is high, no unit raises a match bit in the following cycle.
- R5: Each unit's period counter advances on every end-of-period strobe and wraps to 0 after it reaches the period maximum. Matching is allowed only while the period counter equals the trigger value. With trigger 0 and maximum 0, every period is eligible.
- R6: While a unit is disabled, its period counter is held at 0.
- R7: A write to a live register takes effect in the next cycle. A shadow register's content is copied to its live register at an end-of-period strobe, but only if the shadow was written since its last copy. A live write in the same cycle as a copy wins.
- R8: While the counter holds a matching value for several cycles, the unit raises exactly one pulse.
- R9: A pulse sets the unit's sticky status bit. A write to the status address with data bit i set clears status bit i. A pulse arriving in the same cycle as the clear wins.
- R10: Write address map. Address bit 5 = 0 selects a unit register: bits [4:2] give the unit, and bits [1:0] give the register (0 value live, 1 value shadow, 2 mode live, 3 mode shadow). Value data: [15:0] compare value, [31] direction. Mode data: [0] enable, [11:8] trigger, [19:16] period maximum. Address bit 5 = 1 is the status clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_i | input | 16 | Shared PWM counter value |
| cnt_down_i | input | 1 | Counter is counting down |
| center_i | input | 1 | Counter runs center-aligned |
| eop_i | input | 1 | End-of-period strobe, one cycle |
| fault_i | input | 1 | Fault active on the reference channel |
| wr_en_i | input | 1 | Register write strobe, always accepted |
| wr_addr_i | input | 6 | Register write address |
| wr_data_i | input | 32 | Register write data |
| match_o | output | 8 | One-cycle match pulse per unit |
| status_o | output | 8 | Sticky match flag per unit |

## Verification
A wrong live or shadow register shows at the ports as a missing or extra match pulse. This appears at the first counter crossing after the faulty copy, which is often one end-of-period strobe later. A period counter that is off by one shifts which periods produce pulses, and the shift becomes visible within one full skip cycle of the period maximum. A stuck edge detector or sticky bit shows in the very next cycle as a repeated pulse or a status bit that clears or fails to set. The bench therefore runs a cycle-accurate model beside the design and compares both outputs on every cycle. Directed sequences also count pulses over whole skip cycles.

// File: rtl/pcmp_pkg.sv
`timescale 1ns/1ps
package pcmp_pkg;
  localparam int DATA_W  = 32;
  localparam int DIR_BIT = 31;
  localparam int EN_BIT  = 0;
  localparam int TRG_LSB = 8;
  localparam int MAX_LSB = 16;

  typedef enum logic [1:0] {
    REG_VAL_LIVE    = 2'd0,
    REG_VAL_SHADOW  = 2'd1,
    REG_MODE_LIVE   = 2'd2,
    REG_MODE_SHADOW = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pcmp_shadow.sv
`timescale 1ns/1ps
// Live register with a shadow copy that moves in at the period boundary.
module pcmp_shadow #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         swap_i,
  input  logic         we_live_i,
  input  logic         we_shadow_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] live_o
);
  logic [W-1:0] live_q;
  logic [W-1:0] shadow_q;
  logic         pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q   <= '0;
      shadow_q <= '0;
      pend_q   <= 1'b0;
    end else begin
      // R7: direct write beats a boundary copy
      if (we_live_i)
        live_q <= wdata_i;
      else if (swap_i && pend_q)
        live_q <= shadow_q;

      if (we_shadow_i) begin
        shadow_q <= wdata_i;
        pend_q   <= 1'b1;
      end else if (swap_i) begin
        pend_q   <= 1'b0;
      end
    end
  end

  assign live_o = live_q;
endmodule

// File: rtl/pcmp_unit.sv
`timescale 1ns/1ps
module pcmp_unit
  import pcmp_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PER_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cnt_down_i,
  input  logic             center_i,
  input  logic             eop_i,
  input  logic             fault_i,
  input  logic [3:0]       wsel_i,
  input  logic [CNT_W:0]   val_word_i,
  input  logic [2*PER_W:0] mode_word_i,
  output logic             hit_o
);
  localparam int VW = CNT_W + 1;
  localparam int MW = 2 * PER_W + 1;

  logic [VW-1:0]    val_live;
  logic [MW-1:0]    mode_live;
  logic [CNT_W-1:0] cmp_val;
  logic             dir_sel;
  logic             unit_en;
  logic [PER_W-1:0] trg_val;
  logic [PER_W-1:0] per_max;
  logic [PER_W-1:0] per_cnt_q;
  logic             cond;
  logic             cond_q;
  logic             hit_q;

  pcmp_shadow #(.W(VW)) u_val (
    .clk         (clk),
    .rst_n       (rst_n),
    .swap_i      (eop_i),
    .we_live_i   (wsel_i[int'(REG_VAL_LIVE)]),
    .we_shadow_i (wsel_i[int'(REG_VAL_SHADOW)]),
    .wdata_i     (val_word_i),
    .live_o      (val_live)
  );

  pcmp_shadow #(.W(MW)) u_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .swap_i      (eop_i),
    .we_live_i   (wsel_i[int'(REG_MODE_LIVE)]),
    .we_shadow_i (wsel_i[int'(REG_MODE_SHADOW)]),
    .wdata_i     (mode_word_i),
    .live_o      (mode_live)
  );

  assign cmp_val = val_live[CNT_W-1:0];
  assign dir_sel = val_live[CNT_W];
  assign unit_en = mode_live[0];
  assign trg_val = mode_live[PER_W:1];
  assign per_max = mode_live[2*PER_W:PER_W+1];

  // R5/R6: period-skip counter
  always_ff @(posedge clk) begin
    if (!rst_n || !unit_en)
      per_cnt_q <= '0;
    else if (eop_i)
      per_cnt_q <= (per_cnt_q >= per_max) ? '0 : per_cnt_q + 1'b1;
  end

  always_comb begin
    cond = unit_en && !fault_i && (per_cnt_q == trg_val) && (cnt_i == cmp_val);
    if (center_i && (cnt_down_i != dir_sel))
      cond = 1'b0;
  end

  // R8: one pulse per crossing
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cond_q <= 1'b0;
      hit_q  <= 1'b0;
    end else begin
      cond_q <= cond;
      hit_q  <= cond && !cond_q;
    end
  end

  assign hit_o = hit_q;
endmodule

// File: rtl/pcmp_status.sv
`timescale 1ns/1ps
module pcmp_status #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] status_o
);
  logic [N-1:0] flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      flag_q <= '0;
    else
      flag_q <= (flag_q & ~clr_i) | set_i;
  end

  assign status_o = flag_q;
endmodule

// File: rtl/pcmp_bank.sv
`timescale 1ns/1ps
module pcmp_bank
  import pcmp_pkg::*;
#(
  parameter int N_UNITS = 8,
  parameter int CNT_W   = 16,
  parameter int PER_W   = 4,
  localparam int UIW    = (N_UNITS > 1) ? $clog2(N_UNITS) : 1,
  localparam int AW     = UIW + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              cnt_down_i,
  input  logic              center_i,
  input  logic              eop_i,
  input  logic              fault_i,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [N_UNITS-1:0] match_o,
  output logic [N_UNITS-1:0] status_o
);
  logic [CNT_W:0]       val_word;
  logic [2*PER_W:0]     mode_word;
  logic                 unit_space;
  logic [UIW-1:0]       unit_idx;
  logic [N_UNITS-1:0]   hits;
  logic [N_UNITS-1:0]   clr_vec;
  logic                 unused_wdata;

  assign val_word   = {wr_data_i[DIR_BIT], wr_data_i[CNT_W-1:0]};
  assign mode_word  = {wr_data_i[MAX_LSB +: PER_W], wr_data_i[TRG_LSB +: PER_W],
                       wr_data_i[EN_BIT]};
  assign unit_space = wr_en_i && !wr_addr_i[AW-1];
  assign unit_idx   = wr_addr_i[2 +: UIW];
  assign clr_vec    = (wr_en_i && wr_addr_i[AW-1]) ? wr_data_i[N_UNITS-1:0] : '0;
  assign unused_wdata = ^wr_data_i;

  for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
    logic [3:0] wsel;
    assign wsel = (unit_space && (unit_idx == UIW'(u))) ? (4'b0001 << wr_addr_i[1:0]) : 4'b0000;

    pcmp_unit #(.CNT_W(CNT_W), .PER_W(PER_W)) u_unit (
      .clk         (clk),
      .rst_n       (rst_n),
      .cnt_i       (cnt_i),
      .cnt_down_i  (cnt_down_i),
      .center_i    (center_i),
      .eop_i       (eop_i),
      .fault_i     (fault_i),
      .wsel_i      (wsel),
      .val_word_i  (val_word),
      .mode_word_i (mode_word),
      .hit_o       (hits[u])
    );
  end

  pcmp_status #(.N(N_UNITS)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (hits),
    .clr_i    (clr_vec),
    .status_o (status_o)
  );

  assign match_o = hits;
endmodule

// File: rtl/pcmp_bank_chk.sv
`timescale 1ns/1ps
module pcmp_bank_chk #(
  parameter int N  = 8,
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fault_i,
  input logic          wr_en_i,
  input logic [AW-1:0] wr_addr_i,
  input logic [31:0]   wr_data_i,
  input logic [N-1:0]  match_o,
  input logic [N-1:0]  status_o
);
  logic stat_wr;
  assign stat_wr = wr_en_i && wr_addr_i[AW-1];

  a_r4_fault_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    fault_i |=> (match_o == '0));

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (match_o != '0) |=> ((match_o & $past(match_o)) == '0));

  a_r9_pulse_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (match_o != '0) |=> ((status_o & $past(match_o)) == $past(match_o)));

  a_r9_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |=> ((status_o & $past(wr_data_i[N-1:0] & ~match_o)) == '0));

  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr |=> (($past(status_o) & ~status_o) == '0));
endmodule

bind pcmp_bank pcmp_bank_chk #(.N(N_UNITS), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fault_i   (fault_i),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .match_o   (match_o),
  .status_o  (status_o)
);

// File: tb/pcmp_bank_bench.sv
`timescale 1ns/1ps
module pcmp_bank_bench;
  localparam int N = 8;
  localparam int CW = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic [CW-1:0] cnt = '0;
  logic          down = 1'b0, center = 1'b0, eop = 1'b0, fault = 1'b0, wr_en = 1'b0;
  logic [5:0]    wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic [N-1:0]  match_o, status_o;

  pcmp_bank u_pcmp_bank (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .cnt_down_i(down), .center_i(center),
    .eop_i(eop), .fault_i(fault), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .match_o(match_o), .status_o(status_o)
  );

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;
  int pulses [N];

  // reference model state
  logic [CW-1:0] m_cv [N], m_cvb [N];
  logic          m_ds [N], m_dsb [N], m_en [N], m_enb [N], m_vp [N], m_mp [N], m_cond [N];
  logic [3:0]    m_trg [N], m_trgb [N], m_max [N], m_maxb [N], m_pc [N];
  logic [N-1:0]  exp_match = '0, exp_stat = '0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] ra(input int u, input int r);
    return {1'b0, u[2:0], r[1:0]};
  endfunction

  function automatic bit m_hit(input int u);
    bit c;
    c = m_en[u] && !fault && (m_pc[u] == m_trg[u]) && (cnt == m_cv[u]);
    if (center && (down != m_ds[u])) c = 1'b0;
    return c;
  endfunction

  always @(posedge clk) begin : mdl
    logic [N-1:0] nm;
    logic [N-1:0] clr;
    if (!rst_n) begin
      for (int u = 0; u < N; u++) begin
        m_cv[u] = '0; m_cvb[u] = '0; m_ds[u] = 0; m_dsb[u] = 0; m_en[u] = 0; m_enb[u] = 0;
        m_vp[u] = 0; m_mp[u] = 0; m_cond[u] = 0; m_trg[u] = 0; m_trgb[u] = 0;
        m_max[u] = 0; m_maxb[u] = 0; m_pc[u] = 0;
      end
      exp_match = '0; exp_stat = '0;
    end else begin
      nm = '0;
      for (int u = 0; u < N; u++) begin
        bit c, ws;
        c = m_hit(u);
        nm[u] = c && !m_cond[u];
        m_cond[u] = c;
        if (!m_en[u]) m_pc[u] = 0;
        else if (eop) m_pc[u] = (m_pc[u] >= m_max[u]) ? 4'd0 : m_pc[u] + 4'd1;
        ws = wr_en && !wr_addr[5] && (wr_addr[4:2] == u[2:0]);
        if (ws && wr_addr[1:0] == 2'd0) begin m_cv[u] = wr_data[15:0]; m_ds[u] = wr_data[31]; end
        else if (eop && m_vp[u]) begin m_cv[u] = m_cvb[u]; m_ds[u] = m_dsb[u]; end
        if (ws && wr_addr[1:0] == 2'd1) begin m_cvb[u] = wr_data[15:0]; m_dsb[u] = wr_data[31]; m_vp[u] = 1; end
        else if (eop) m_vp[u] = 0;
        if (ws && wr_addr[1:0] == 2'd2) begin
          m_en[u] = wr_data[0]; m_trg[u] = wr_data[11:8]; m_max[u] = wr_data[19:16];
        end else if (eop && m_mp[u]) begin
          m_en[u] = m_enb[u]; m_trg[u] = m_trgb[u]; m_max[u] = m_maxb[u];
        end
        if (ws && wr_addr[1:0] == 2'd3) begin
          m_enb[u] = wr_data[0]; m_trgb[u] = wr_data[11:8]; m_maxb[u] = wr_data[19:16]; m_mp[u] = 1;
        end else if (eop) m_mp[u] = 0;
      end
      clr = (wr_en && wr_addr[5]) ? wr_data[N-1:0] : '0;
      exp_stat = (exp_stat & ~clr) | exp_match;
      exp_match = nm;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(match_o == exp_match, "R2 match vs model", 32'(match_o), 32'(exp_match));
      chk(status_o == exp_stat, "R9 status vs model", 32'(status_o), 32'(exp_stat));
      for (int u = 0; u < N; u++) pulses[u] += int'(match_o[u]);
    end
  end

  task automatic cyc(input int c, input bit dn, input bit e);
    cnt = CW'(c); down = dn; eop = e;
    @(negedge clk); #1;
    eop = 1'b0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic zero_pulses();
    for (int u = 0; u < N; u++) pulses[u] = 0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2468));
    cnt = 16'd999;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    chk(match_o == '0, "R1 match after reset", 32'(match_o), 0);
    chk(status_o == '0, "R1 status after reset", 32'(status_o), 0);
    cyc(0, 0, 0);
    chk(match_o == '0, "R1 disabled unit ignores value 0", 32'(match_o), 0);

    // basic match on unit 2
    wr(ra(2, 0), 32'd100);
    wr(ra(2, 2), 32'h1);
    cyc(100, 0, 0);
    chk(match_o == 8'h04, "R2 R10 pulse on unit 2 only", 32'(match_o), 32'h04);
    cyc(100, 0, 0);
    chk(match_o == '0, "R8 no second pulse", 32'(match_o), 0);
    cyc(100, 0, 0);
    chk(match_o == '0, "R8 still held", 32'(match_o), 0);
    cyc(999, 0, 0);
    chk(status_o == 8'h04, "R9 sticky set", 32'(status_o), 32'h04);
    wr(6'h20, 32'h4);
    chk(status_o == '0, "R9 cleared", 32'(status_o), 0);

    // direction qualifier
    center = 1'b1;
    wr(ra(2, 0), 32'h8000_0064);
    cyc(100, 0, 0);
    chk(match_o == '0, "R3 up-count rejected", 32'(match_o), 0);
    cyc(999, 0, 0);
    cyc(100, 1, 0);
    chk(match_o == 8'h04, "R3 down-count accepted", 32'(match_o), 32'h04);
    cyc(999, 1, 0);
    center = 1'b0;
    cyc(100, 0, 0);
    chk(match_o == 8'h04, "R3 left mode ignores direction", 32'(match_o), 32'h04);
    cyc(999, 0, 0);

    // fault
    fault = 1'b1;
    cyc(100, 0, 0);
    chk(match_o == '0, "R4 fault suppresses", 32'(match_o), 0);
    fault = 1'b0;
    cyc(100, 0, 0);
    chk(match_o == 8'h04, "R4 match after fault release", 32'(match_o), 32'h04);
    cyc(999, 0, 0);

    // period skipping on unit 5: trigger 2, max 3
    wr(ra(5, 0), 32'd7);
    wr(ra(5, 2), 32'h0003_0201);
    zero_pulses();
    for (int p = 0; p < 12; p++) begin cyc(7, 0, 0); cyc(9, 0, 1); end
    chk(pulses[5] == 3, "R5 one of four periods", 32'(pulses[5]), 3);
    zero_pulses();
    for (int p = 0; p < 4; p++) begin cyc(100, 0, 0); cyc(9, 0, 1); end
    chk(pulses[2] == 4, "R5 every period when zero", 32'(pulses[2]), 4);

    // disable clears period counter
    cyc(9, 0, 1); cyc(9, 0, 1);
    wr(ra(5, 2), 32'h0);
    wr(ra(5, 2), 32'h0003_0001);
    zero_pulses();
    cyc(7, 0, 0);
    chk(pulses[5] == 1, "R6 period counter restarted", 32'(pulses[5]), 1);

    // shadow registers
    wr(ra(5, 2), 32'h1);
    wr(ra(5, 1), 32'd20);
    zero_pulses();
    cyc(20, 0, 0);
    chk(pulses[5] == 0, "R7 shadow not live yet", 32'(pulses[5]), 0);
    cyc(7, 0, 0);
    chk(pulses[5] == 1, "R7 old value still live", 32'(pulses[5]), 1);
    cyc(9, 0, 1);
    cyc(20, 0, 0);
    chk(pulses[5] == 2, "R7 value copied at boundary", 32'(pulses[5]), 2);
    wr(ra(5, 0), 32'd30);
    cyc(9, 0, 1);
    cyc(30, 0, 0);
    chk(pulses[5] == 3, "R7 no stale copy", 32'(pulses[5]), 3);
    wr(ra(5, 3), 32'h0001_0101);
    cyc(9, 0, 0); cyc(30, 0, 0);
    cyc(9, 0, 1); cyc(30, 0, 0);
    cyc(9, 0, 1); cyc(30, 0, 0);
    chk(pulses[5] == 5, "R7 mode shadow copied", 32'(pulses[5]), 5);

    // random phase, checked each cycle against the model
    for (int i = 0; i < 3000; i++) begin
      cnt    = CW'($urandom_range(0, 7));
      down   = 1'($urandom_range(0, 1));
      center = 1'($urandom_range(0, 1));
      eop    = ($urandom_range(0, 5) == 0);
      fault  = ($urandom_range(0, 11) == 0);
      wr_en  = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 9) == 0) wr_addr = 6'h20;
      else wr_addr = {1'b0, 5'($urandom_range(0, 31))};
      wr_data = {1'($urandom_range(0, 1)), 11'd0, 4'($urandom_range(0, 3)),
                 4'd0, 4'($urandom_range(0, 3)), 5'd0, 3'($urandom_range(0, 7))};
      if (wr_addr[5]) wr_data = $urandom;
      @(negedge clk); #1;
    end
    wr_en = 1'b0; eop = 1'b0; fault = 1'b0;
    cyc(999, 0, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule